// File: doc/BRIEF.md
# CAVLC Coefficient Symbol Extractor

This block accepts the sixteen quantized coefficients of one 4x4 transform block in raster order. It reorders them along the zig-zag scan and turns them into the syntax elements that a context-adaptive variable-length coder consumes. Those elements are the nonzero count paired with the trailing-ones count, the signs of the trailing ones, the remaining levels, the number of zeros lying below the last nonzero coefficient, and the run of zeros in front of each nonzero coefficient.

Each element leaves as one tagged symbol on a valid/ready stream, one symbol per cycle while the consumer is ready. A downstream coder maps the symbols to codewords and packs bits. That coder also supplies the neighbour context for the count symbol. A new block is taken only after the last symbol of the previous one has been accepted.

The sequencer has six states:
- `ST_IDLE` waits for a block and goes to `ST_COUNT` on acceptance.
- `ST_COUNT` leaves for `ST_IDLE` when the block is all zero, for `ST_SIGN` when trailing ones exist, and for `ST_LEVEL` otherwise.
- `ST_SIGN` leaves, after its last sign, for `ST_LEVEL`, or for `ST_TOTZ` when every nonzero coefficient was a trailing one.
- `ST_LEVEL` leaves, after its last level, for `ST_TOTZ`, or for `ST_IDLE` when all sixteen are nonzero.
- `ST_TOTZ` leaves for `ST_RUN`, or for `ST_IDLE` when no run is due.
- `ST_RUN` returns to `ST_IDLE` on its final symbol.

Top module: `cavlc_sym_extract`

## Requirements
- R1: After reset `in_ready` is 1 and `sym_valid` is 0.
- R2: A block is taken on a clock edge where `in_valid` and `in_ready` are both 1. Raster coefficient r (row*4+column) sits in `in_coefs[16r+15:16r]` as a signed value. Scan position p reads raster index 0,1,4,8,5,2,3,6,9,12,13,10,7,11,14,15 for p = 0..15, and position 15 is the highest frequency. The first symbol is valid in the cycle after the accepting edge.
- R3: The first symbol has tag 0. Its value holds the nonzero total (0..16) in bits [4:0] and the trailing-ones count in bits [6:5], with all other bits 0.
- R4: Trailing ones are counted over the nonzero coefficients from the highest scan position downward. Counting stops at the first magnitude other than 1, or at 3. One tag-1 symbol per trailing one follows, highest position first, with value 1 for -1 and 0 for +1.
- R5: Every other nonzero coefficient follows as a tag-2 symbol carrying the full signed value, from high scan position to low.
- R6: When the total is 1 to 15, a tag-3 symbol follows. Its value is the number of zero coefficients below the highest nonzero position.
- R7: After it, tag-4 symbols give, for each nonzero coefficient from high to low, the zeros between it and the next lower nonzero one. Emission stops once the zeros still unassigned reach 0, and no symbol is given for the lowest nonzero coefficient.
- R8: `sym_last` marks the final symbol of a block. An all-zero block yields only the tag-0 symbol with value 0 and `sym_last` set. `in_ready` is 1 in the cycle after the final symbol is accepted.
- R9: With `sym_ready` held at 1, a block of N symbols occupies exactly N consecutive valid cycles.
- R10: While `sym_valid` is 1 and `sym_ready` is 0, the tag, value and last flag stay unchanged in the next cycle, and `sym_valid` stays 1.
- R11: `in_ready` is 0 whenever `sym_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A coefficient block is offered |
| in_ready | output | 1 | The block is free to accept a new one |
| in_coefs | input | 16*COEF_W | Sixteen signed coefficients in raster order |
| sym_valid | output | 1 | A symbol is presented |
| sym_ready | input | 1 | The consumer takes the symbol |
| sym_tag | output | 3 | Symbol kind: 0 count, 1 sign, 2 level, 3 total zeros, 4 run |
| sym_value | output | COEF_W | Symbol payload |
| sym_last | output | 1 | Final symbol of the block |

## Verification
The first symbol of a block is due one cycle after the accepting edge. Each later symbol is due one cycle after the edge that accepted its predecessor, and `in_ready` returns one cycle after the final acceptance. The bench drives inputs and samples all outputs on the falling edge, so every observation falls midway between the edge that produced it and the edge that consumes it. A handshake is counted only when valid and ready are both seen high at that sample. Under a held-high ready the bench counts valid cycles per block against the expected symbol count. Under random ready it compares each stalled symbol with the one seen on the previous falling edge.

// File: rtl/cavlc_pkg.sv
package cavlc_pkg;

    localparam int NCOEF = 16;
    localparam int IDX_W = $clog2(NCOEF);
    localparam int CNT_W = IDX_W + 1;

    typedef enum logic [2:0] {
        TAG_COUNT = 3'd0,
        TAG_SIGN  = 3'd1,
        TAG_LEVEL = 3'd2,
        TAG_TOTZ  = 3'd3,
        TAG_RUN   = 3'd4
    } sym_tag_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_SIGN,
        ST_LEVEL,
        ST_TOTZ,
        ST_RUN
    } ext_state_e;

    // scan position -> raster index of a 4x4 block
    function automatic logic [IDX_W-1:0] scan_src(input logic [IDX_W-1:0] p);
        logic [IDX_W-1:0] r;
        unique case (p)
            4'd0:  r = 4'd0;
            4'd1:  r = 4'd1;
            4'd2:  r = 4'd4;
            4'd3:  r = 4'd8;
            4'd4:  r = 4'd5;
            4'd5:  r = 4'd2;
            4'd6:  r = 4'd3;
            4'd7:  r = 4'd6;
            4'd8:  r = 4'd9;
            4'd9:  r = 4'd12;
            4'd10: r = 4'd13;
            4'd11: r = 4'd10;
            4'd12: r = 4'd7;
            4'd13: r = 4'd11;
            4'd14: r = 4'd14;
            default: r = 4'd15;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cavlc_zz_scan.sv
module cavlc_zz_scan
    import cavlc_pkg::*;
#(
    parameter int COEF_W = 16
) (
    input  logic [NCOEF*COEF_W-1:0] raster,
    output logic [NCOEF*COEF_W-1:0] scan
);

    for (genvar p = 0; p < NCOEF; p++) begin : g_pos
        localparam int SRC = int'(scan_src(IDX_W'(p)));
        assign scan[p*COEF_W +: COEF_W] = raster[SRC*COEF_W +: COEF_W];
    end

endmodule

// File: rtl/cavlc_blk_stats.sv
module cavlc_blk_stats
    import cavlc_pkg::*;
#(
    parameter int COEF_W = 16
) (
    input  logic [NCOEF*COEF_W-1:0] scan,
    output logic [NCOEF-1:0]        nz_mask,
    output logic [CNT_W-1:0]        total,
    output logic [1:0]              t1_cnt,
    output logic [CNT_W-1:0]        tot_zeros
);

    logic [NCOEF-1:0] unit_mag;

    for (genvar p = 0; p < NCOEF; p++) begin : g_flag
        assign nz_mask[p]  = |scan[p*COEF_W +: COEF_W];
        assign unit_mag[p] = (scan[p*COEF_W +: COEF_W] == COEF_W'(1)) ||
                             (scan[p*COEF_W +: COEF_W] == {COEF_W{1'b1}});
    end

    logic [CNT_W-1:0] top_plus1;

    always_comb begin
        logic halted;
        total     = '0;
        top_plus1 = '0;
        for (int p = 0; p < NCOEF; p++) begin
            total = total + CNT_W'(nz_mask[p]);
            if (nz_mask[p]) top_plus1 = CNT_W'(p + 1);
        end
        t1_cnt = '0;
        halted = 1'b0;
        for (int p = NCOEF - 1; p >= 0; p--) begin
            if (nz_mask[p] && !halted) begin
                if (unit_mag[p] && t1_cnt != 2'd3) t1_cnt = t1_cnt + 2'd1;
                else                               halted = 1'b1;
            end
        end
        tot_zeros = top_plus1 - total;
    end

endmodule

// File: rtl/cavlc_msb_find.sv
module cavlc_msb_find
    import cavlc_pkg::*;
(
    input  logic [NCOEF-1:0] vec,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int p = 0; p < NCOEF; p++) begin
            if (vec[p]) idx = IDX_W'(p);
        end
    end

endmodule

// File: rtl/cavlc_sym_extract.sv
module cavlc_sym_extract
    import cavlc_pkg::*;
#(
    parameter int COEF_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [NCOEF*COEF_W-1:0] in_coefs,
    output logic                    sym_valid,
    input  logic                    sym_ready,
    output logic [2:0]              sym_tag,
    output logic [COEF_W-1:0]       sym_value,
    output logic                    sym_last
);

    localparam int PAD_CNT = COEF_W - 2 - CNT_W;

    ext_state_e state, state_nx;

    logic [NCOEF*COEF_W-1:0] blk_raster;
    logic [NCOEF*COEF_W-1:0] blk_scan;
    logic [NCOEF-1:0]        nz_mask;
    logic [CNT_W-1:0]        total;
    logic [1:0]              t1_cnt;
    logic [CNT_W-1:0]        tot_zeros;

    logic [NCOEF-1:0]        rem;
    logic [1:0]              sgn_left;
    logic [CNT_W-1:0]        lev_left;
    logic [CNT_W-1:0]        zeros_left;
    logic [CNT_W-1:0]        coefs_left;

    logic [IDX_W-1:0]        cur_pos;
    logic [IDX_W-1:0]        nxt_pos;
    logic [NCOEF-1:0]        rem_less;
    logic [COEF_W-1:0]       cur_coef;
    logic [CNT_W-1:0]        run_val;

    logic                    in_fire;
    logic                    out_fire;

    cavlc_zz_scan #(.COEF_W(COEF_W)) u_scan (
        .raster (blk_raster),
        .scan   (blk_scan)
    );

    cavlc_blk_stats #(.COEF_W(COEF_W)) u_stats (
        .scan      (blk_scan),
        .nz_mask   (nz_mask),
        .total     (total),
        .t1_cnt    (t1_cnt),
        .tot_zeros (tot_zeros)
    );

    cavlc_msb_find u_cur (
        .vec (rem),
        .idx (cur_pos)
    );

    assign rem_less = rem & ~(NCOEF'(1) << cur_pos);

    cavlc_msb_find u_nxt (
        .vec (rem_less),
        .idx (nxt_pos)
    );

    assign cur_coef = blk_scan[cur_pos*COEF_W +: COEF_W];
    assign run_val  = {1'b0, cur_pos} - {1'b0, nxt_pos} - CNT_W'(1);
    assign in_fire  = in_valid && in_ready;
    assign out_fire = sym_valid && sym_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (in_valid) state_nx = ST_COUNT;
            end
            ST_COUNT: begin
                if (out_fire) begin
                    if (sym_last)           state_nx = ST_IDLE;
                    else if (t1_cnt != '0)  state_nx = ST_SIGN;
                    else                    state_nx = ST_LEVEL;
                end
            end
            ST_SIGN: begin
                if (out_fire && sgn_left == 2'd1) begin
                    if (lev_left == '0) state_nx = ST_TOTZ;
                    else                state_nx = ST_LEVEL;
                end
            end
            ST_LEVEL: begin
                if (out_fire && lev_left == CNT_W'(1)) begin
                    if (sym_last) state_nx = ST_IDLE;
                    else          state_nx = ST_TOTZ;
                end
            end
            ST_TOTZ: begin
                if (out_fire) begin
                    if (sym_last) state_nx = ST_IDLE;
                    else          state_nx = ST_RUN;
                end
            end
            ST_RUN: begin
                if (out_fire && sym_last) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = (state == ST_IDLE);
        sym_valid = (state != ST_IDLE);
        sym_tag   = 3'(TAG_COUNT);
        sym_value = '0;
        sym_last  = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_COUNT: begin
                sym_tag   = 3'(TAG_COUNT);
                sym_value = {{PAD_CNT{1'b0}}, t1_cnt, total};
                sym_last  = (total == '0);
            end
            ST_SIGN: begin
                sym_tag   = 3'(TAG_SIGN);
                sym_value = {{(COEF_W-1){1'b0}}, cur_coef[COEF_W-1]};
            end
            ST_LEVEL: begin
                sym_tag   = 3'(TAG_LEVEL);
                sym_value = cur_coef;
                sym_last  = (lev_left == CNT_W'(1)) && (total == CNT_W'(NCOEF));
            end
            ST_TOTZ: begin
                sym_tag   = 3'(TAG_TOTZ);
                sym_value = {{(COEF_W-CNT_W){1'b0}}, tot_zeros};
                sym_last  = (tot_zeros == '0) || (total == CNT_W'(1));
            end
            ST_RUN: begin
                sym_tag   = 3'(TAG_RUN);
                sym_value = {{(COEF_W-CNT_W){1'b0}}, run_val};
                sym_last  = (zeros_left == run_val) || (coefs_left == CNT_W'(2));
            end
            default: begin
            end
        endcase
    end

    // per-block working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_raster <= '0;
            rem        <= '0;
            sgn_left   <= '0;
            lev_left   <= '0;
            zeros_left <= '0;
            coefs_left <= '0;
        end else begin
            if (in_fire) blk_raster <= in_coefs;
            if (out_fire) begin
                unique case (state)
                    ST_COUNT: begin
                        rem      <= nz_mask;
                        sgn_left <= t1_cnt;
                        lev_left <= total - CNT_W'(t1_cnt);
                    end
                    ST_SIGN: begin
                        rem      <= rem_less;
                        sgn_left <= sgn_left - 2'd1;
                    end
                    ST_LEVEL: begin
                        rem      <= rem_less;
                        lev_left <= lev_left - CNT_W'(1);
                    end
                    ST_TOTZ: begin
                        rem        <= nz_mask;
                        zeros_left <= tot_zeros;
                        coefs_left <= total;
                    end
                    ST_RUN: begin
                        rem        <= rem_less;
                        zeros_left <= zeros_left - run_val;
                        coefs_left <= coefs_left - CNT_W'(1);
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/cavlc_sym_extract_chk.sv
module cavlc_sym_extract_chk
    import cavlc_pkg::*;
#(
    parameter int COEF_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              sym_valid,
    input logic              sym_ready,
    input logic [2:0]        sym_tag,
    input logic [COEF_W-1:0] sym_value,
    input logic              sym_last
);

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid && !sym_ready |=> sym_valid && $stable(sym_tag) && $stable(sym_value) && $stable(sym_last)); // R10

    AST_IN_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> !in_ready); // R11

    AST_COUNT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> sym_valid && sym_tag == 3'(TAG_COUNT)); // R2

    AST_COUNT_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid && sym_tag == 3'(TAG_COUNT) |->
            sym_value[4:0] <= 5'd16 && 5'(sym_value[6:5]) <= sym_value[4:0] && sym_value[COEF_W-1:7] == '0); // R3

    AST_SIGN_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid && sym_tag == 3'(TAG_SIGN) |-> sym_value[COEF_W-1:1] == '0); // R4

    AST_LAST_FREES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid && sym_ready && sym_last |=> in_ready && !sym_valid); // R8

    AST_TAG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> sym_tag <= 3'(TAG_RUN)); // R3

endmodule

bind cavlc_sym_extract cavlc_sym_extract_chk #(.COEF_W(COEF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .sym_valid (sym_valid),
    .sym_ready (sym_ready),
    .sym_tag   (sym_tag),
    .sym_value (sym_value),
    .sym_last  (sym_last)
);

// File: tb/sim_cavlc_sym_extract.sv
module sim_cavlc_sym_extract;

    localparam int CLK_P = 10;
    localparam int W     = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [16*W-1:0] in_coefs = '0;
    logic           sym_valid;
    logic           sym_ready = 1'b0;
    logic [2:0]     sym_tag;
    logic [W-1:0]   sym_value;
    logic           sym_last;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    cavlc_sym_extract #(.COEF_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_coefs(in_coefs), .sym_valid(sym_valid), .sym_ready(sym_ready),
        .sym_tag(sym_tag), .sym_value(sym_value), .sym_last(sym_last)
    );

    int zz_tab [16] = '{0, 1, 4, 8, 5, 2, 3, 6, 9, 12, 13, 10, 7, 11, 14, 15};

    logic signed [W-1:0] coef_r [16];
    logic [2:0]   e_tag  [40];
    logic [W-1:0] e_val  [40];
    logic         e_last [40];
    int           e_n;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] t);
        case (t)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5/R2";
            3'd3: return "R6/R2";
            default: return "R7";
        endcase
    endfunction

    task automatic push(input logic [2:0] t, input logic [W-1:0] v);
        e_tag[e_n] = t; e_val[e_n] = v; e_last[e_n] = 1'b0; e_n++;
    endtask

    task automatic build_expect();
        logic signed [W-1:0] zz [16];
        int pos [16];
        int tot, t1, totz, zl;
        bit stop;
        e_n = 0; tot = 0; t1 = 0; stop = 0;
        for (int p = 0; p < 16; p++) zz[p] = coef_r[zz_tab[p]];
        for (int p = 15; p >= 0; p--) begin
            if (zz[p] != 0) begin
                pos[tot] = p;
                if (!stop && (zz[p] == 1 || zz[p] == -1) && t1 < 3) t1++;
                else stop = 1;
                tot++;
            end
        end
        push(3'd0, W'((t1 << 5) | tot));
        for (int k = 0; k < t1; k++) push(3'd1, W'(zz[pos[k]] < 0 ? 1 : 0));
        for (int k = t1; k < tot; k++) push(3'd2, zz[pos[k]]);
        if (tot > 0 && tot < 16) begin
            totz = pos[0] + 1 - tot;
            push(3'd3, W'(totz));
            zl = totz;
            for (int k = 0; k < tot - 1 && zl > 0; k++) begin
                push(3'd4, W'(pos[k] - pos[k+1] - 1));
                zl = zl - (pos[k] - pos[k+1] - 1);
            end
        end
        e_last[e_n-1] = 1'b1;
    endtask

    // called on a falling edge; returns on a falling edge
    task automatic run_block(input bit rnd_ready);
        int got, cycles, lim;
        bit stalled;
        logic [2:0] s_tag; logic [W-1:0] s_val; logic s_last;
        build_expect();
        for (int r = 0; r < 16; r++) in_coefs[r*W +: W] = coef_r[r];
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready == 1'b0 && sym_valid == 1'b1, "R11", "in_ready/sym_valid after accept",
              {in_ready, sym_valid}, 2'b01);
        got = 0; cycles = 0; lim = 0; stalled = 0;
        while (got < e_n && lim < 200) begin
            bit rdy;
            lim++;
            if (sym_valid) cycles++;
            if (stalled)
                check(sym_valid && sym_tag == s_tag && sym_value == s_val && sym_last == s_last,
                      "R10", "symbol held under stall", {sym_tag, sym_value}, {s_tag, s_val});
            rdy = rnd_ready ? ($urandom % 3 != 0) : 1'b1;
            sym_ready = rdy;
            stalled = sym_valid && !rdy;
            s_tag = sym_tag; s_val = sym_value; s_last = sym_last;
            if (sym_valid && rdy) begin
                check(sym_tag == e_tag[got] && sym_value == e_val[got], req_of(e_tag[got]),
                      $sformatf("symbol %0d tag/value", got),
                      {sym_tag, sym_value}, {e_tag[got], e_val[got]});
                check(sym_last == e_last[got], "R8", $sformatf("symbol %0d last", got),
                      sym_last, e_last[got]);
                got++;
            end
            @(negedge clk);
        end
        sym_ready = 1'b0;
        check(got == e_n, "R8", "symbols received", got, e_n);
        check(in_ready == 1'b1 && sym_valid == 1'b0, "R8", "in_ready after final symbol",
              {in_ready, sym_valid}, 2'b10);
        if (!rnd_ready) check(cycles == e_n, "R9", "valid cycles per block", cycles, e_n);
    endtask

    function automatic logic signed [W-1:0] rand_coef();
        case ($urandom % 8)
            0, 1, 2, 3: return '0;
            4: return 16'sd1;
            5: return -16'sd1;
            6: return ($urandom % 2) ? W'(2 + $urandom % 19) : -W'(2 + $urandom % 19);
            default: return W'($urandom);
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1729));
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1 && sym_valid == 1'b0, "R1", "reset state", {in_ready, sym_valid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1 && sym_valid == 1'b0, "R1", "idle after reset", {in_ready, sym_valid}, 2'b10);

        // R8: all-zero block
        for (int r = 0; r < 16; r++) coef_r[r] = '0;
        run_block(1'b0);
        // R5/R9: all sixteen +1, three trailing ones and thirteen levels, no total-zeros
        for (int r = 0; r < 16; r++) coef_r[r] = 16'sd1;
        run_block(1'b0);
        // R6: single -1 at highest scan position
        for (int r = 0; r < 16; r++) coef_r[r] = '0;
        coef_r[15] = -16'sd1;
        run_block(1'b0);
        // R6: single level at DC, total zeros 0
        coef_r[15] = '0; coef_r[0] = 16'sd5;
        run_block(1'b1);
        // R4/R7: trailing-one chain broken by magnitude 2, gaps in the scan
        coef_r[0] = 16'sd3; coef_r[4] = -16'sd1; coef_r[6] = 16'sd1;
        coef_r[12] = -16'sd2; coef_r[11] = 16'sd1; coef_r[14] = -16'sd1;
        run_block(1'b0);
        // R5: extreme values
        for (int r = 0; r < 16; r++) coef_r[r] = '0;
        coef_r[1] = 16'sh8000; coef_r[9] = 16'sh7fff; coef_r[13] = 16'sd1;
        run_block(1'b1);

        for (int b = 0; b < 80; b++) begin
            for (int r = 0; r < 16; r++) coef_r[r] = rand_coef();
            run_block(b[0]);
        end

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule